// File: doc/BRIEF.md
# Sector Target Search Controller

This block supervises a disc sector decoder. The host programs a target sector address in minute/second/frame BCD form and a decoded-sector limit, and arms a target search. The search does not begin until the host separately starts the decoder. While the decoder runs, the block compares each incoming sector header with the target and raises a found, overshoot or not-found flag. It also counts end-of-EDC-check strobes against the limit and records the header-compare-error, last-block and masked status-error events.

All events land in sticky flags, which the host clears by writing ones. A single registered interrupt line is the OR of the flags whose enables are set. Unless the host has taken manual control, any enabled stop condition halts the decoder-run output on the same clock edge that records the event. The control settings survive a decoder stop, so a restart needs only a write to the run register.

Register map (3-bit address): 0 control; 1 run (bit 0: write 1 starts, write 0 stops); 2, 3 and 4 target minute, second and frame (BCD); 5 sector limit; 6 flags (read) and write-one-to-clear (write); 7 count (read) and status mask (write, low bits). Control bits are: 0 arm, 1 count enable, 2 manual (host-only run), 3 compare-error interrupt enable, 4 not-found interrupt enable, 5 overshoot interrupt enable, 6 last-block enable. Flag bits are: 0 compare error, 1 not found, 2 overshoot, 3 last block, 4 count full, 5 status error, 6 target found. Read data is registered and appears one cycle after the read address.

Top module: `sector_seek_ctrl`

## Requirements
- R1: After reset, run_o, irq_o and flags_o are 0, the control register reads 0 (so the manual bit is low and auto-stop is active), and the count reads 0.
- R2: Writing the arm bit (control bit 0) does not raise run_o. While run_o is low, headers set no flag.
- R3: With the search armed and the decoder started by writing 1 to run bit 0, a header whose frame number (minute×4500 + second×75 + frame) equals the target sets flag bit 6. Headers below the target set nothing. Flag bit 6 always reaches irq_o, one cycle after the flag.
- R4: A header above the target before any match sets flag bit 2 and ends the search, so a later matching header does not set bit 6.
- R5: When 16 headers pass after the start without a match or an overshoot, flag bit 1 sets on the 16th and not before.
- R6: Starting the decoder clears the count, and each EDC strobe while running increments it. Flag bit 4 sets when the incremented count equals the limit, and only if control bit 1 is set.
- R7: With the manual bit low, an enabled stop event (compare error with bit 3, not-found with bit 4, overshoot with bit 5, last block, count full, status error) drops run_o on the edge that records it. A compare error with bit 3 clear sets its flag but leaves run_o high.
- R8: With the manual bit high, run_o stays high through enabled stop events until the host writes 0 to run bit 0.
- R9: Flag bits 0, 1 and 2 drive irq_o only while control bits 3, 4 and 5 respectively are set.
- R10: Flag bit 3 sets on a last-block pulse only with control bit 6 set. Flag bit 5 sets only when a status-error input bit is set that is also set in the status mask.
- R11: Writing ones to address 6 clears exactly those flags. The control, target and limit registers keep their values across a decoder stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 3 | Host read address |
| rd_data | output | 8 | Registered read data |
| hdr_stb | input | 1 | Sector header valid pulse |
| hdr_msf | input | 24 | Header minute/second/frame, BCD |
| edc_stb | input | 1 | End of EDC check pulse |
| hce_stb | input | 1 | Header compare error pulse |
| lastblk_stb | input | 1 | Last block pulse |
| stat_err | input | 4 | Status error bits |
| flags_o | output | 7 | Sticky status flags |
| irq_o | output | 1 | Summary interrupt |
| run_o | output | 1 | Decoder run |

## Verification
A wrong search state shows at flags_o on the edge after the header that should have ended or extended the search. A stale search shows up as a match reported after an overshoot. A miscounted header total moves the not-found flag off the 16th header. A counter error shows as a count-full flag on the wrong EDC strobe or a wrong count readback. A wrong stop mask shows as run_o falling or staying high on the event edge, and a wrong interrupt mask shows on irq_o one cycle later.

// File: rtl/sts_pkg.sv
package sts_pkg;
  localparam int FLG_N = 7;
  localparam int F_HCE = 0;
  localparam int F_TNF = 1;
  localparam int F_LTT = 2;
  localparam int F_LBK = 3;
  localparam int F_CFL = 4;
  localparam int F_SER = 5;
  localparam int F_FND = 6;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_RUN  = 3'd1;
  localparam logic [2:0] A_TMIN = 3'd2;
  localparam logic [2:0] A_TSEC = 3'd3;
  localparam logic [2:0] A_TFRM = 3'd4;
  localparam logic [2:0] A_LIM  = 3'd5;
  localparam logic [2:0] A_FLG  = 3'd6;
  localparam logic [2:0] A_AUX  = 3'd7;

  localparam int C_ARM = 0;
  localparam int C_CNT = 1;
  localparam int C_MAN = 2;
  localparam int C_HIE = 3;
  localparam int C_NIE = 4;
  localparam int C_LIE = 5;
  localparam int C_LBE = 6;
endpackage

// File: rtl/bcd_frame.sv
module bcd_frame #(
  parameter int FRN_W = 20
) (
  input  logic [23:0]      msf,
  output logic [FRN_W-1:0] frn
);
  logic [FRN_W-1:0] mins, secs, frms;

  always_comb begin
    mins = FRN_W'(msf[23:20]) * FRN_W'(10) + FRN_W'(msf[19:16]);
    secs = FRN_W'(msf[15:12]) * FRN_W'(10) + FRN_W'(msf[11:8]);
    frms = FRN_W'(msf[7:4])   * FRN_W'(10) + FRN_W'(msf[3:0]);
    frn  = mins * FRN_W'(4500) + secs * FRN_W'(75) + frms;
  end
endmodule

// File: rtl/target_tracker.sv
module target_tracker #(
  parameter int FRN_W   = 20,
  parameter int NF_HDRS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             arm,
  input  logic             run,
  input  logic             hdr_stb,
  input  logic [FRN_W-1:0] hdr_frn,
  input  logic [FRN_W-1:0] tgt_frn,
  output logic             found_p,
  output logic             ltt_p,
  output logic             tnf_p
);
  localparam int HC_W = $clog2(NF_HDRS + 1);
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(NF_HDRS - 1);

  logic            searching;
  logic [HC_W-1:0] hcnt;
  logic            act, eq, gt;

  always_comb begin
    eq      = (hdr_frn == tgt_frn);
    gt      = (hdr_frn > tgt_frn);
    act     = hdr_stb && run && searching && !start;
    found_p = act && eq;
    ltt_p   = act && gt;
    tnf_p   = act && !eq && !gt && (hcnt == HC_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      searching <= 1'b0;
      hcnt      <= '0;
    end else if (start) begin
      searching <= arm;
      hcnt      <= '0;
    end else if (act) begin
      if (eq || gt || hcnt == HC_LAST) searching <= 1'b0;
      else hcnt <= hcnt + 1'b1;
    end
  end

  // R5: a search ends once; the cycle after any ending event is quiet
  p_single_end_r5: assert property (@(posedge clk) disable iff (rst)
    (found_p || ltt_p || tnf_p) |=> !(found_p || ltt_p || tnf_p));
endmodule

// File: rtl/sector_counter.sv
module sector_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic             edc_stb,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             full_p
);
  logic [CNT_W-1:0] nxt;
  logic             step;

  always_comb begin
    step   = run && edc_stb && !start;
    nxt    = count + 1'b1;
    full_p = step && cnt_en && (nxt == limit);
  end

  always_ff @(posedge clk) begin
    if (rst || start) count <= '0;
    else if (step)    count <= nxt;
  end

  // R6: count-full is reported exactly when the stored count reaches the limit
  p_full_at_limit_r6: assert property (@(posedge clk) disable iff (rst)
    full_p |=> (count == $past(limit)));
endmodule

// File: rtl/sector_seek_ctrl.sv
module sector_seek_ctrl #(
  parameter int FRN_W   = 20,
  parameter int NF_HDRS = 16,
  parameter int CNT_W   = 8,
  parameter int STAT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [2:0]        rd_addr,
  output logic [7:0]        rd_data,
  input  logic              hdr_stb,
  input  logic [23:0]       hdr_msf,
  input  logic              edc_stb,
  input  logic              hce_stb,
  input  logic              lastblk_stb,
  input  logic [STAT_W-1:0] stat_err,
  output logic [6:0]        flags_o,
  output logic              irq_o,
  output logic              run_o
);
  import sts_pkg::*;

  logic [7:0]        ctrl_q, tmin_q, tsec_q, tfrm_q;
  logic [CNT_W-1:0]  lim_q, count;
  logic [STAT_W-1:0] smask_q;
  logic [FLG_N-1:0]  flags_q, evt, ien, sen, clr;
  logic              run_q, irq_q;
  logic              start, stopw, found_p, ltt_p, tnf_p, full_p;
  logic [FRN_W-1:0]  hdr_frn, tgt_frn;

  always_comb begin
    start = wr_en && wr_addr == A_RUN && wr_data[0];
    stopw = wr_en && wr_addr == A_RUN && !wr_data[0];
    clr   = (wr_en && wr_addr == A_FLG) ? wr_data[FLG_N-1:0] : '0;
    evt        = '0;
    evt[F_HCE] = hce_stb && run_q;
    evt[F_TNF] = tnf_p;
    evt[F_LTT] = ltt_p;
    evt[F_LBK] = lastblk_stb && run_q && ctrl_q[C_LBE];
    evt[F_CFL] = full_p;
    evt[F_SER] = run_q && |(stat_err & smask_q);
    evt[F_FND] = found_p;
    ien        = '1;
    ien[F_HCE] = ctrl_q[C_HIE];
    ien[F_TNF] = ctrl_q[C_NIE];
    ien[F_LTT] = ctrl_q[C_LIE];
    sen        = ien;
    sen[F_FND] = 1'b0;
  end

  bcd_frame #(.FRN_W(FRN_W)) hdr_cv_i (.msf(hdr_msf), .frn(hdr_frn));
  bcd_frame #(.FRN_W(FRN_W)) tgt_cv_i (.msf({tmin_q, tsec_q, tfrm_q}), .frn(tgt_frn));

  target_tracker #(.FRN_W(FRN_W), .NF_HDRS(NF_HDRS)) trk_i (
    .clk(clk), .rst(rst), .start(start), .arm(ctrl_q[C_ARM]), .run(run_q),
    .hdr_stb(hdr_stb), .hdr_frn(hdr_frn), .tgt_frn(tgt_frn),
    .found_p(found_p), .ltt_p(ltt_p), .tnf_p(tnf_p));

  sector_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .start(start), .run(run_q), .edc_stb(edc_stb),
    .cnt_en(ctrl_q[C_CNT]), .limit(lim_q), .count(count), .full_p(full_p));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0; tmin_q <= '0; tsec_q <= '0; tfrm_q <= '0;
      lim_q <= '0; smask_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:  ctrl_q  <= wr_data;
        A_TMIN:  tmin_q  <= wr_data;
        A_TSEC:  tsec_q  <= wr_data;
        A_TFRM:  tfrm_q  <= wr_data;
        A_LIM:   lim_q   <= CNT_W'(wr_data);
        A_AUX:   smask_q <= wr_data[STAT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      flags_q <= '0;
      irq_q   <= 1'b0;
      rd_data <= '0;
    end else begin
      flags_q <= (flags_q & ~clr) | evt;
      irq_q   <= |(flags_q & ien);
      if (start)                                     run_q <= 1'b1;
      else if (stopw)                                run_q <= 1'b0;
      else if (!ctrl_q[C_MAN] && |(evt & sen))       run_q <= 1'b0;
      case (rd_addr)
        A_CTRL:  rd_data <= ctrl_q;
        A_RUN:   rd_data <= {7'd0, run_q};
        A_TMIN:  rd_data <= tmin_q;
        A_TSEC:  rd_data <= tsec_q;
        A_TFRM:  rd_data <= tfrm_q;
        A_LIM:   rd_data <= 8'(lim_q);
        A_FLG:   rd_data <= {1'b0, flags_q};
        default: rd_data <= 8'(count);
      endcase
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = irq_q;
  assign run_o   = run_q;

  // R8: under manual control the decoder only stops on a host write
  p_manual_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (run_q && ctrl_q[C_MAN] && !(wr_en && wr_addr == A_RUN)) |=> run_o);
  // R7: an enabled compare error stops the decoder in auto mode
  p_autostop_hce_r7: assert property (@(posedge clk) disable iff (rst)
    (run_q && !ctrl_q[C_MAN] && hce_stb && ctrl_q[C_HIE] && !(wr_en && wr_addr == A_RUN))
    |=> !run_o);
  // R9: no interrupt follows an all-clear flag set
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (flags_q == '0) |=> !irq_o);
  // R2: headers seen while stopped leave the search flags untouched
  p_idle_headers_r2: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !start) |=> ($past(flags_q[F_FND]) >= flags_q[F_FND]) &&
                           ($past(flags_q[F_LTT]) >= flags_q[F_LTT]));
endmodule

// File: tb/sector_seek_ctrl_tb_top.sv
module sector_seek_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic hdr_stb = 1'b0, edc_stb = 1'b0, hce_stb = 1'b0, lastblk_stb = 1'b0;
  logic [23:0] hdr_msf = '0;
  logic [3:0] stat_err = '0;
  logic [6:0] flags_o;
  logic irq_o, run_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sector_seek_ctrl dut_i (.*);

  localparam logic [7:0] ARM = 8'h01, CNT = 8'h02, MAN = 8'h04, HIE = 8'h08,
                         NIE = 8'h10, LIE = 8'h20, LBE = 8'h40;

  function automatic logic [7:0] to_bcd(int x);
    return 8'(((x / 10) << 4) | (x % 10));
  endfunction
  function automatic logic [23:0] lin2msf(int f);
    return {to_bcd(f / 4500), to_bcd((f % 4500) / 75), to_bcd(f % 75)};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask
  task automatic hdr(logic [23:0] m);
    @(negedge clk); hdr_stb = 1'b1; hdr_msf = m;
    @(negedge clk); hdr_stb = 1'b0;
  endtask
  task automatic edc();
    @(negedge clk); edc_stb = 1'b1; @(negedge clk); edc_stb = 1'b0;
  endtask
  task automatic hce();
    @(negedge clk); hce_stb = 1'b1; @(negedge clk); hce_stb = 1'b0;
  endtask
  task automatic lbk();
    @(negedge clk); lastblk_stb = 1'b1; @(negedge clk); lastblk_stb = 1'b0;
  endtask
  task automatic serr(logic [3:0] v);
    @(negedge clk); stat_err = v; @(negedge clk); stat_err = '0;
  endtask
  task automatic restart(logic [7:0] c);
    wr(3'd0, c); wr(3'd6, 8'h7f); wr(3'd1, 8'h01);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 run", run_o, 0); chk("R1 flags", flags_o, 0); chk("R1 irq", irq_o, 0);
    rd(3'd0, d); chk("R1 ctrl", d, 0);
    rd(3'd7, d); chk("R1 count", d, 0);

    // R2 arming alone
    wr(3'd0, ARM | MAN);
    chk("R2 run after arm", run_o, 0);
    hdr(24'h000000);
    chk("R2 idle header flags", flags_o, 0);

    // R3 target match
    wr(3'd2, 8'h01); wr(3'd3, 8'h02); wr(3'd4, 8'h03);
    restart(ARM | MAN);
    chk("R3 run started", run_o, 1);
    hdr(24'h010200);
    chk("R3 below target", flags_o, 0);
    hdr(24'h010203);
    chk("R3 found flag", flags_o, 7'h40);
    @(negedge clk);
    chk("R3 found irq", irq_o, 1);

    // R4 overshoot, R9 enable gating
    restart(ARM | MAN);
    hdr(24'h010205);
    chk("R4 ltt flag", flags_o, 7'h04);
    @(negedge clk);
    chk("R9 ltt masked irq", irq_o, 0);
    wr(3'd0, ARM | MAN | LIE);
    @(negedge clk);
    chk("R9 ltt enabled irq", irq_o, 1);
    hdr(24'h010203);
    chk("R4 no match after overshoot", flags_o, 7'h04);

    // R5 not found after 16 headers
    restart(ARM | MAN);
    repeat (15) hdr(24'h000010);
    chk("R5 15 headers", flags_o, 0);
    hdr(24'h000010);
    chk("R5 16th header", flags_o, 7'h02);

    // R6 / R7 count full with auto-stop
    wr(3'd5, 8'd3);
    restart(CNT);
    edc(); edc();
    chk("R6 before limit", flags_o, 0);
    chk("R7 still running", run_o, 1);
    rd(3'd7, d); chk("R6 count 2", d, 2);
    edc();
    chk("R6 count full", flags_o, 7'h10);
    chk("R7 stop on count full", run_o, 0);
    rd(3'd7, d); chk("R6 count 3", d, 3);
    restart(MAN);
    rd(3'd7, d); chk("R6 count cleared", d, 0);
    edc(); edc(); edc();
    chk("R6 no full without enable", flags_o, 0);

    // R7 compare error stop, R9
    restart(HIE);
    hce();
    chk("R7 stop on hce", run_o, 0);
    chk("R7 hce flag", flags_o, 7'h01);
    @(negedge clk);
    chk("R9 hce irq", irq_o, 1);
    restart(8'h00);
    hce();
    chk("R7 unmasked hce keeps run", run_o, 1);
    chk("R7 hce flag set", flags_o, 7'h01);
    @(negedge clk);
    chk("R9 hce masked irq", irq_o, 0);

    // R10 status mask and last block
    wr(3'd7, 8'h02);
    restart(MAN | LBE);
    serr(4'b0001);
    chk("R10 unmasked status", flags_o, 0);
    serr(4'b0010);
    chk("R10 masked status", flags_o, 7'h20);
    lbk();
    chk("R10 last block", flags_o, 7'h28);
    restart(MAN);
    lbk();
    chk("R10 last block disabled", flags_o, 0);

    // R8 manual hold
    restart(MAN | HIE | LBE);
    hce(); lbk();
    chk("R8 manual run kept", run_o, 1);
    // R11 selective clear
    wr(3'd6, 8'h01);
    chk("R11 partial clear", flags_o, 7'h08);
    wr(3'd1, 8'h00);
    chk("R8 host stop", run_o, 0);
    rd(3'd0, d); chk("R11 ctrl kept", d, MAN | HIE | LBE);
    rd(3'd4, d); chk("R11 target kept", d, 8'h03);
    rd(3'd5, d); chk("R11 limit kept", d, 3);

    // random target searches (R3, R4)
    for (int t = 0; t < 30; t++) begin
      int tg, n, st, f;
      logic [23:0] tm;
      tg = 100 + int'($urandom % 400000);
      tm = lin2msf(tg);
      wr(3'd2, tm[23:16]); wr(3'd3, tm[15:8]); wr(3'd4, tm[7:0]);
      restart(ARM | MAN | LIE);
      st = 0;
      n = 1 + int'($urandom % 5);
      for (int h = 0; h < n; h++) begin
        f = tg + int'($urandom % 5) - 3;
        hdr(lin2msf(f));
        if (st == 0) st = (f == tg) ? 1 : (f > tg) ? 2 : 0;
      end
      chk("R3 R4 random search flags", flags_o & 7'h44,
          st == 1 ? 7'h40 : st == 2 ? 7'h04 : 0);
      @(negedge clk);
      chk("R3 R4 random irq", irq_o, st != 0 ? 1 : 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule